// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block sits between a small processor core's data-memory port and an external asynchronous SRAM. The SRAM is reached over two 8-bit pin groups. The low group first carries the low address byte and then the data byte. An external transparent latch captures that low address byte under the address-latch strobe. The high group holds the upper address byte for the whole access. Active-low read and write strobes qualify the single data cycle.

The core presents an address, write data, a direction bit and a valid bit. The block accepts the request only when the bus mode is on and the address lies above the internal RAM limit. It then runs a fixed sequence of three cycles, or four when the extra-wait control bit is set. A one-cycle done pulse returns the read data. When the bus mode is off, both pin groups follow their ordinary GPIO direction and value settings, and no strobes are produced.

Top module: `xsram_bus_ctrl`

## Requirements
- R1: A request is accepted only when `cfgEnable` is 1 and `reqAddr` is strictly greater than the `INT_LIMIT` parameter (default 16'h0FFF). Any other request is ignored: busy stays low, no done pulse, `ale` stays 0, and `rdN`/`wrN` stay 1.
- R2: The first cycle after acceptance is the address cycle. In it `ale` is 1, `padHighOut` shows address bits [15:8], `padLowOut` shows address bits [7:0] with `padLowOe` = 8'hFF, and both strobes are 1.
- R3: `ale` is high for exactly one cycle per access. The low address byte stays on `padLowOut` in the cycle where `ale` falls and in the optional wait cycle.
- R4: `busy` is 1 for exactly 3 cycles per access when `cfgWait` = 0, and for 4 cycles when `cfgWait` = 1. `done` is 1 for one cycle immediately after the last busy cycle, with `busy` = 0.
- R5: In a write, `wrN` is 0 only in the last busy cycle. In that cycle `padLowOut` carries the write data with `padLowOe` = 8'hFF, and `rdN` stays 1.
- R6: In a read, `rdN` is 0 only in the last busy cycle, and `padLowOe` = 8'h00 there. The value on `padLowIn` at the end of that cycle appears on `rdData` while `done` is 1.
- R7: `rdN` and `wrN` are never 0 together, and both are 1 after reset and whenever no access is in its data cycle.
- R8: After the data cycle, the low pin group returns to driving the low address byte (`padLowOe` = 8'hFF).
- R9: A new request presented during the `done` cycle is accepted at the next clock edge. No turnaround cycle is inserted, whatever the directions of the two accesses.
- R10: With `cfgEnable` = 0, `padLowOut`/`padLowOe` equal `gpioLowOut`/`gpioLowDir`, `padHighOut`/`padHighOe` equal `gpioHighOut`/`gpioHighDir`, `ale` = 0, and `rdN` = `wrN` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgEnable | input | 1 | Bus mode on; when 0 the pins act as GPIO |
| cfgWait | input | 1 | Adds one wait cycle to every access |
| reqValid | input | 1 | Core request valid |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Request address |
| reqWdata | input | 8 | Write data |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Read data, valid with done |
| gpioLowDir | input | 8 | GPIO direction for the low pin group |
| gpioLowOut | input | 8 | GPIO value for the low pin group |
| gpioHighDir | input | 8 | GPIO direction for the high pin group |
| gpioHighOut | input | 8 | GPIO value for the high pin group |
| padLowIn | input | 8 | Value sensed on the low pin group |
| padLowOut | output | 8 | Value driven on the low pin group |
| padLowOe | output | 8 | Per-bit output enable, low pin group |
| padHighOut | output | 8 | Value driven on the high pin group |
| padHighOe | output | 8 | Per-bit output enable, high pin group |
| ale | output | 1 | Address latch strobe |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |

## Verification
The bench runs writes and reads with both wait settings. Each address uses a different low byte and high byte, so a bench latch-plus-array model returns stale or misrouted data if the latched low byte or the high byte is wrong. A write followed at once by a read, presented in the done cycle, shows whether a turnaround cycle is added. Requests at the internal limit and requests made while the mode is off show whether anything reaches the pins. A later read of the same location proves that the write made while the mode was off had no effect.

// File: rtl/xsram_pkg.sv
package xsram_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_LATCH,
    ST_WAIT,
    ST_DATA
  } busState_t;

  typedef struct packed {
    logic load;      // capture request into datapath registers
    logic ale;       // address latch strobe
    logic dataPhase; // low pins act as data bus
    logic rdLow;     // read strobe active, sample read data
    logic wrLow;     // write strobe active
  } busStrobes_t;
endpackage

// File: rtl/xsram_ctrl.sv
module xsram_ctrl
  import xsram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned INT_LIMIT = 16'h0FFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgEnable,
  input  logic              cfgWait,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  output busStrobes_t       strb,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] LimitVal = ADDR_W'(INT_LIMIT);

  busState_t stateQ, stateD;
  logic      isWriteQ;
  logic      doneQ;
  logic      accept;

  assign accept = (stateQ == ST_IDLE) && reqValid && cfgEnable && (reqAddr > LimitVal);

  always_comb begin
    stateD = stateQ;
    unique case (stateQ)
      ST_IDLE:  if (accept) stateD = ST_ADDR;
      ST_ADDR:  stateD = ST_LATCH;
      ST_LATCH: stateD = cfgWait ? ST_WAIT : ST_DATA;
      ST_WAIT:  stateD = ST_DATA;
      ST_DATA:  stateD = ST_IDLE;
      default:  stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWriteQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stateQ <= stateD;
      doneQ  <= (stateQ == ST_DATA);
      if (accept) isWriteQ <= reqWrite;
    end
  end

  always_comb begin
    strb.load      = accept;
    strb.ale       = (stateQ == ST_ADDR);
    strb.dataPhase = (stateQ == ST_DATA);
    strb.rdLow     = (stateQ == ST_DATA) && !isWriteQ;
    strb.wrLow     = (stateQ == ST_DATA) && isWriteQ;
  end

  assign busy = (stateQ != ST_IDLE);
  assign done = doneQ;

  // R1
  accept_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(cfgEnable) && ($past(reqAddr) > LimitVal)));
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/xsram_datapath.sv
module xsram_datapath
  import xsram_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  busStrobes_t              strb,
  input  logic                     cfgEnable,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  input  logic [DATA_W-1:0]        gpioLowDir,
  input  logic [DATA_W-1:0]        gpioLowOut,
  input  logic [ADDR_W-DATA_W-1:0] gpioHighDir,
  input  logic [ADDR_W-DATA_W-1:0] gpioHighOut,
  input  logic [DATA_W-1:0]        padLowIn,
  output logic [DATA_W-1:0]        padLowOut,
  output logic [DATA_W-1:0]        padLowOe,
  output logic [ADDR_W-DATA_W-1:0] padHighOut,
  output logic [ADDR_W-DATA_W-1:0] padHighOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN,
  output logic [DATA_W-1:0]        rdData
);
  localparam int unsigned HI_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      rdQ    <= '0;
    end else begin
      if (strb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.rdLow) rdQ <= padLowIn;
    end
  end

  always_comb begin
    if (cfgEnable) begin
      padLowOut  = (strb.dataPhase && strb.wrLow) ? wdataQ : addrQ[DATA_W-1:0];
      padLowOe   = strb.rdLow ? '0 : '1;
      padHighOut = addrQ[ADDR_W-1:DATA_W];
      padHighOe  = '1;
      ale        = strb.ale;
      rdN        = !strb.rdLow;
      wrN        = !strb.wrLow;
    end else begin
      padLowOut  = gpioLowOut;
      padLowOe   = gpioLowDir;
      padHighOut = gpioHighOut;
      padHighOe  = gpioHighDir;
      ale        = 1'b0;
      rdN        = 1'b1;
      wrN        = 1'b1;
    end
  end

  assign rdData = rdQ;

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));
  // R6
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |-> (padLowOe == '0));
  // R6
  read_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdN |=> rdN);
  // R5
  write_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    !wrN |=> wrN);
  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgEnable && $fell(ale)) |-> (padLowOut == $past(padLowOut)));
  // R10
  gpio_fallback_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cfgEnable |-> (!ale && rdN && wrN && padLowOe == gpioLowDir
                    && padHighOe == gpioHighDir));
  // R3
  ale_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> !ale);

  logic [HI_W-1:0] unusedHi;
  assign unusedHi = '0;
endmodule

// File: rtl/xsram_bus_ctrl.sv
module xsram_bus_ctrl
  import xsram_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned INT_LIMIT = 16'h0FFF
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgEnable,
  input  logic                     cfgWait,
  input  logic                     reqValid,
  input  logic                     reqWrite,
  input  logic [ADDR_W-1:0]        reqAddr,
  input  logic [DATA_W-1:0]        reqWdata,
  output logic                     busy,
  output logic                     done,
  output logic [DATA_W-1:0]        rdData,
  input  logic [DATA_W-1:0]        gpioLowDir,
  input  logic [DATA_W-1:0]        gpioLowOut,
  input  logic [ADDR_W-DATA_W-1:0] gpioHighDir,
  input  logic [ADDR_W-DATA_W-1:0] gpioHighOut,
  input  logic [DATA_W-1:0]        padLowIn,
  output logic [DATA_W-1:0]        padLowOut,
  output logic [DATA_W-1:0]        padLowOe,
  output logic [ADDR_W-DATA_W-1:0] padHighOut,
  output logic [ADDR_W-DATA_W-1:0] padHighOe,
  output logic                     ale,
  output logic                     rdN,
  output logic                     wrN
);
  busStrobes_t strb;

  xsram_ctrl #(.ADDR_W(ADDR_W), .INT_LIMIT(INT_LIMIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWait(cfgWait),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .strb(strb), .busy(busy), .done(done)
  );

  xsram_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgEnable(cfgEnable),
    .reqAddr(reqAddr), .reqWdata(reqWdata),
    .gpioLowDir(gpioLowDir), .gpioLowOut(gpioLowOut),
    .gpioHighDir(gpioHighDir), .gpioHighOut(gpioHighOut),
    .padLowIn(padLowIn), .padLowOut(padLowOut), .padLowOe(padLowOe),
    .padHighOut(padHighOut), .padHighOe(padHighOe),
    .ale(ale), .rdN(rdN), .wrN(wrN), .rdData(rdData)
  );
endmodule

// File: tb/xsram_bus_ctrl_bench.sv
module xsram_bus_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgEnable = 1'b0, cfgWait = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        busy, done;
  logic [7:0]  rdData;
  logic [7:0]  gpioLowDir = '0, gpioLowOut = '0, gpioHighDir = '0, gpioHighOut = '0;
  logic [7:0]  padLowIn, padLowOut, padLowOe, padHighOut, padHighOe;
  logic        ale, rdN, wrN;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk; // 50 MHz

  xsram_bus_ctrl u_xsram_bus_ctrl (
    .clk(clk), .rstN(rstN), .cfgEnable(cfgEnable), .cfgWait(cfgWait),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .busy(busy), .done(done), .rdData(rdData),
    .gpioLowDir(gpioLowDir), .gpioLowOut(gpioLowOut),
    .gpioHighDir(gpioHighDir), .gpioHighOut(gpioHighOut),
    .padLowIn(padLowIn), .padLowOut(padLowOut), .padLowOe(padLowOe),
    .padHighOut(padHighOut), .padHighOe(padHighOe),
    .ale(ale), .rdN(rdN), .wrN(wrN)
  );

  // External transparent latch and SRAM model
  logic [7:0] latchQ = '0;
  logic [7:0] sram [256];
  logic [7:0] sramIdx;
  always @(*) if (ale) latchQ = padLowOut;
  assign sramIdx  = latchQ ^ padHighOut;
  assign padLowIn = rdN ? 8'h00 : sram[sramIdx];
  always @(posedge clk) if (!wrN) sram[sramIdx] <= padLowOut;

  // Scoreboard
  typedef struct {
    logic [15:0] addr;
    logic        write;
    logic [7:0]  wdata;
    logic [7:0]  expRd;
    int          len;
  } item_t;
  item_t       q[$];
  logic [7:0]  refMem [256];
  int          phase = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) begin
        phase++;
        if (q.size() == 0) check(1'b0, "R1 unexpected busy", 1, 0);
        else begin
          if (phase == 1) begin
            check(ale && padHighOut == q[0].addr[15:8] && padLowOut == q[0].addr[7:0]
                  && padLowOe == 8'hFF && rdN && wrN, "R2 address cycle",
                  {ale, padHighOut, padLowOut}, {1'b1, q[0].addr});
          end else if (phase < q[0].len) begin
            check(!ale && padLowOut == q[0].addr[7:0] && rdN && wrN,
                  "R3 address held", {ale, padLowOut}, {1'b0, q[0].addr[7:0]});
          end else if (q[0].write) begin
            check(!wrN && rdN && padLowOe == 8'hFF && padLowOut == q[0].wdata,
                  "R5 write data cycle", {wrN, rdN, padLowOut}, {2'b01, q[0].wdata});
          end else begin
            check(!rdN && wrN && padLowOe == 8'h00, "R6 read data cycle",
                  {rdN, wrN, padLowOe}, {2'b01, 8'h00});
          end
        end
      end
      if (done) begin
        if (q.size() == 0) check(1'b0, "R4 done without request", 1, 0);
        else begin
          item_t it;
          it = q.pop_front();
          check(!busy && phase == it.len, "R4 access length", phase, it.len);
          if (!it.write) check(rdData == it.expRd, "R6 read data", rdData, it.expRd);
          check(padLowOut == it.addr[7:0] && padLowOe == 8'hFF, "R8 back to address",
                padLowOut, it.addr[7:0]);
        end
        phase = 0;
      end
    end
  end

  task automatic issue(input logic [15:0] a, input bit wr, input logic [7:0] d,
                       input bit expAccept, input string req);
    if (expAccept) begin
      item_t it;
      logic [7:0] idx;
      idx = a[7:0] ^ a[15:8];
      if (wr) refMem[idx] = d;
      it.addr = a; it.write = wr; it.wdata = d; it.expRd = refMem[idx];
      it.len = cfgWait ? 4 : 3;
      q.push_back(it);
    end
    reqAddr = a; reqWrite = wr; reqWdata = d; reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    check(busy == expAccept, req, busy, expAccept);
  endtask

  task automatic waitDone();
    while (!done) @(negedge clk);
  endtask

  task automatic quietCycles(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(!busy && !done && !ale && rdN && wrN, req, {busy, done, ale, rdN, wrN}, 5'b00011);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      sram[i] = 8'h00;
      refMem[i] = 8'h00;
    end
    repeat (3) @(negedge clk);
    // R7 reset state
    check(!busy && !done && rdN && wrN && !ale, "R7 reset state",
          {busy, done, rdN, wrN, ale}, 5'b00110);
    rstN = 1'b1;
    @(negedge clk);
    cfgEnable = 1'b1;
    cfgWait = 1'b0;
    // R2 R4 R5 R6 three-cycle accesses
    issue(16'h1234, 1'b1, 8'hA5, 1'b1, "R1 accept write"); waitDone(); @(negedge clk);
    issue(16'h2055, 1'b1, 8'h3C, 1'b1, "R1 accept write"); waitDone(); @(negedge clk);
    issue(16'h1234, 1'b0, 8'h00, 1'b1, "R1 accept read");  waitDone(); @(negedge clk);
    issue(16'h2055, 1'b0, 8'h00, 1'b1, "R1 accept read");  waitDone(); @(negedge clk);
    // R4 four-cycle accesses
    cfgWait = 1'b1;
    issue(16'h8001, 1'b1, 8'hF0, 1'b1, "R1 accept write"); waitDone(); @(negedge clk);
    issue(16'h8001, 1'b0, 8'h00, 1'b1, "R1 accept read");  waitDone(); @(negedge clk);
    issue(16'h1234, 1'b0, 8'h00, 1'b1, "R1 accept read");  waitDone(); @(negedge clk);
    // R9 back-to-back write then read, then read then write
    issue(16'h4407, 1'b1, 8'h99, 1'b1, "R1 accept write"); waitDone();
    issue(16'h4407, 1'b0, 8'h00, 1'b1, "R9 accepted in done cycle"); waitDone();
    cfgWait = 1'b0;
    issue(16'hC3C3, 1'b1, 8'h5E, 1'b1, "R9 accepted in done cycle"); waitDone();
    issue(16'hC3C3, 1'b0, 8'h00, 1'b1, "R9 accepted in done cycle"); waitDone();
    @(negedge clk);
    // R1 address at the internal limit is ignored
    issue(16'h0FFF, 1'b1, 8'h11, 1'b0, "R1 internal address ignored");
    quietCycles(5, "R1 no bus activity");
    issue(16'h0800, 1'b0, 8'h00, 1'b0, "R1 internal address ignored");
    quietCycles(5, "R1 no bus activity");
    // R10 GPIO fallback
    cfgEnable = 1'b0;
    gpioLowDir = 8'h5A; gpioLowOut = 8'hC3; gpioHighDir = 8'h0F; gpioHighOut = 8'h81;
    @(negedge clk);
    check(padLowOe == 8'h5A && padLowOut == 8'hC3 && padHighOe == 8'h0F
          && padHighOut == 8'h81 && !ale && rdN && wrN, "R10 GPIO fallback",
          {padLowOe, padLowOut, padHighOe, padHighOut}, 32'h5AC30F81);
    issue(16'h1234, 1'b1, 8'h00, 1'b0, "R1 disabled request ignored");
    quietCycles(5, "R10 no strobes while disabled");
    cfgEnable = 1'b1;
    @(negedge clk);
    // R1 earlier disabled write had no effect
    issue(16'h1234, 1'b0, 8'h00, 1'b1, "R1 accept read"); waitDone(); @(negedge clk);
    check(q.size() == 0, "R4 all accesses completed", q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule